// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block produces the control-memory address for a microprogrammed control unit whose store holds 128 words of 20 bits. On every clock edge it picks the next value of its 7-bit control address register from one of four sources. The sources are the register plus one, the branch target carried in the current microinstruction, a one-level subroutine return register, and an address formed from the 4-bit opcode of the machine instruction. The control store is outside the block. The word read from it at the current address comes back on the `uinstr` input in the same cycle.

The choice depends on two fields of the microinstruction. A 2-bit condition selector picks one of three datapath status bits or a constant one. A 2-bit branch kind then decides how that condition is used:

- **Jump**: go to the target if the condition holds, otherwise fall through.
- **Call**: like a jump, and when taken the return register also captures the fall-through address.
- **Return**: go to the return register.
- **Dispatch**: go to the opcode-mapped address.

Word layout, MSB first:

| Bits | Field | Meaning |
|------|-------|---------|
| [19:11] | datapath operation fields | not decoded by this block |
| [10:9] | condition select | picks the tested condition |
| [8:7] | branch kind | picks how the condition is used |
| [6:0] | target address | branch or call target |

Internal source selection uses four named choices: `SRC_INC`=00, `SRC_RET`=01, `SRC_TGT`=10 and `SRC_MAP`=11. The branch kinds are named `BR_JUMP`, `BR_CALL`, `BR_RET` and `BR_DISP`. Every transition of the address register is one of these four sources, or the reset transition to the fetch entry.

Top module: `mseq_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the control address to 64, clears the return register to 0 and clears `ret_loaded`. A return issued as the first microinstruction after reset therefore goes to address 0.
- R2: The condition select field [10:9] picks the tested condition as follows: 00 is constant 1, 01 is `dr_sign`, 10 is `ac_sign` and 11 is `ac_zero`.
- R3: With branch kind 00 (jump), the next address is the target field [6:0] if the condition is 1, and the current address plus one otherwise.
- R4: With branch kind 01 (call) and the condition at 1, the next address is the target field, and the return register takes the current address plus one.
- R5: With branch kind 01 (call) and the condition at 0, the next address is the current address plus one, and the return register keeps its value.
- R6: With branch kind 10 (return), the next address is the return register's value whatever the condition.
- R7: With branch kind 11 (dispatch), the next address is {0, opcode[3:0], 00}, so opcode n goes to address 4n.
- R8: Incrementing from address 127 wraps to 0.
- R9: Bits [19:11] of the microinstruction have no effect on the address or on `ret_loaded`.
- R10: `ret_loaded` is 1 for exactly the one cycle after each clock edge at which the return register was loaded, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| uinstr | input | 20 | Microinstruction read at the current address |
| dr_sign | input | 1 | Status: data register bit 15 |
| ac_sign | input | 1 | Status: accumulator bit 15 |
| ac_zero | input | 1 | Status: accumulator equals zero |
| opcode | input | 4 | Opcode of the current machine instruction |
| car | output | 7 | Current control address |
| ret_loaded | output | 1 | High for one cycle after the return register is written |

## Verification
A wrong control address shows on `car` at the very next clock edge, because every source feeds the register directly.

A corrupt return register stays hidden until a return executes. At that point `car` takes the bad value, so the bench follows many calls with returns, including a return right after reset. A missed or extra return-register write also shows one cycle later on `ret_loaded`, independently of any return.

The reference model follows `car` and `ret_loaded` on every clock. Status bits and operation bits are chosen at random, so every condition select meets both condition values.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
    localparam int ADDR_W   = 7;
    localparam int OP_W     = 4;
    localparam int OPF_W    = 9;
    localparam int MAP_LSB  = 2;
    localparam int RST_ADDR = 64;
    localparam int WORD_W   = OPF_W + 4 + ADDR_W;

    typedef enum logic [1:0] {
        BR_JUMP = 2'b00,
        BR_CALL = 2'b01,
        BR_RET  = 2'b10,
        BR_DISP = 2'b11
    } br_e;

    typedef enum logic [1:0] {
        SRC_INC = 2'b00,
        SRC_RET = 2'b01,
        SRC_TGT = 2'b10,
        SRC_MAP = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        CS_ONE  = 2'b00,
        CS_DRS  = 2'b01,
        CS_ACS  = 2'b10,
        CS_ACZ  = 2'b11
    } csel_e;

    typedef struct packed {
        logic [OPF_W-1:0]  ops;
        csel_e             csel;
        br_e               br;
        logic [ADDR_W-1:0] tgt;
    } uword_t;
endpackage

// File: rtl/mseq_cond_mux.sv
module mseq_cond_mux
    import mseq_pkg::*;
(
    input  csel_e csel,
    input  logic  dr_sign,
    input  logic  ac_sign,
    input  logic  ac_zero,
    output logic  cond
);
    always_comb begin
        unique case (csel)
            CS_ONE:  cond = 1'b1;
            CS_DRS:  cond = dr_sign;
            CS_ACS:  cond = ac_sign;
            CS_ACZ:  cond = ac_zero;
            default: cond = 1'b1;
        endcase
    end
endmodule

// File: rtl/mseq_src_logic.sv
module mseq_src_logic
    import mseq_pkg::*;
(
    input  br_e   br,
    input  logic  cond,
    output src_e  src,
    output logic  ret_we
);
    always_comb begin
        src    = SRC_INC;
        ret_we = 1'b0;
        unique case (br)
            BR_JUMP: src = cond ? SRC_TGT : SRC_INC;
            BR_CALL: begin
                src    = cond ? SRC_TGT : SRC_INC;
                ret_we = cond;
            end
            BR_RET:  src = SRC_RET;
            BR_DISP: src = SRC_MAP;
            default: src = SRC_INC;
        endcase
    end
endmodule

// File: rtl/mseq_addr_regs.sv
module mseq_addr_regs
    import mseq_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int OW      = OP_W,
    parameter int SHIFT   = MAP_LSB,
    parameter int RSTV    = RST_ADDR
) (
    input  logic          clk,
    input  logic          rst,
    input  src_e          src,
    input  logic [AW-1:0] tgt,
    input  logic [OW-1:0] opcode,
    input  logic          ret_we,
    output logic [AW-1:0] car,
    output logic [AW-1:0] ret_addr,
    output logic          ret_loaded
);
    localparam int PADW = AW - OW;

    logic [AW-1:0] inc_addr;
    logic [AW-1:0] map_addr;
    logic [AW-1:0] nxt_addr;

    assign inc_addr = car + 1'b1;
    assign map_addr = {{PADW{1'b0}}, opcode} << SHIFT;

    always_comb begin
        unique case (src)
            SRC_INC: nxt_addr = inc_addr;
            SRC_RET: nxt_addr = ret_addr;
            SRC_TGT: nxt_addr = tgt;
            SRC_MAP: nxt_addr = map_addr;
            default: nxt_addr = inc_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            car        <= AW'(RSTV);
            ret_addr   <= '0;
            ret_loaded <= 1'b0;
        end else begin
            car        <= nxt_addr;
            ret_loaded <= ret_we;
            if (ret_we) ret_addr <= inc_addr;
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (car == AW'(RSTV)) && (ret_addr == '0) && !ret_loaded);

    p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_INC) |=> car == AW'($past(car) + 1'b1));

    p_ret_r6: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_RET) |=> car == $past(ret_addr));

    p_call_link_r4: assert property (@(posedge clk) disable iff (rst)
        ret_we |=> ret_addr == AW'($past(car) + 1'b1));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !ret_we |=> $stable(ret_addr));

    p_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        ret_we |=> ret_loaded);

    p_nostrobe_r10: assert property (@(posedge clk) disable iff (rst)
        !ret_we |=> !ret_loaded);
endmodule

// File: rtl/mseq_top.sv
module mseq_top
    import mseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] uinstr,
    input  logic              dr_sign,
    input  logic              ac_sign,
    input  logic              ac_zero,
    input  logic [OP_W-1:0]   opcode,
    output logic [ADDR_W-1:0] car,
    output logic              ret_loaded
);
    uword_t            uw;
    logic              cond;
    src_e              src;
    logic              ret_we;
    logic [ADDR_W-1:0] ret_addr;

    assign uw = uword_t'(uinstr);

    mseq_cond_mux u_cond (
        .csel    (uw.csel),
        .dr_sign (dr_sign),
        .ac_sign (ac_sign),
        .ac_zero (ac_zero),
        .cond    (cond)
    );

    mseq_src_logic u_src (
        .br     (uw.br),
        .cond   (cond),
        .src    (src),
        .ret_we (ret_we)
    );

    mseq_addr_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .src        (src),
        .tgt        (uw.tgt),
        .opcode     (opcode),
        .ret_we     (ret_we),
        .car        (car),
        .ret_addr   (ret_addr),
        .ret_loaded (ret_loaded)
    );

    p_map_r7: assert property (@(posedge clk) disable iff (rst)
        (uw.br == BR_DISP) |=> car == {1'b0, $past(opcode), 2'b00});

    p_jump_r3: assert property (@(posedge clk) disable iff (rst)
        (uw.br == BR_JUMP && cond) |=> car == $past(uw.tgt));

    p_uncond_r2: assert property (@(posedge clk) disable iff (rst)
        (uw.csel == CS_ONE && uw.br == BR_JUMP) |=> car == $past(uw.tgt));

    p_known_r9: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(uw.ops) |-> !$isunknown(src));
endmodule

// File: tb/mseq_top_tb.sv
module mseq_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] uinstr = '0;
    logic        dr_sign = 1'b0;
    logic        ac_sign = 1'b0;
    logic        ac_zero = 1'b0;
    logic [3:0]  opcode = '0;
    logic [6:0]  car;
    logic        ret_loaded;

    int total = 0;
    int bad = 0;
    int m_car = 64;
    int m_ret = 0;
    bit m_strobe = 0;
    bit done = 0;

    mseq_top u_dut (
        .clk(clk), .rst(rst), .uinstr(uinstr), .dr_sign(dr_sign),
        .ac_sign(ac_sign), .ac_zero(ac_zero), .opcode(opcode),
        .car(car), .ret_loaded(ret_loaded)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int cs, input int br, input int tgt, input int ops,
                        input int op, input bit d, input bit a, input bit z,
                        input string tag);
        bit c;
        uinstr  = {ops[8:0], cs[1:0], br[1:0], tgt[6:0]};
        opcode  = op[3:0];
        dr_sign = d; ac_sign = a; ac_zero = z;
        case (cs)
            0: c = 1;
            1: c = d;
            2: c = a;
            default: c = z;
        endcase
        m_strobe = 0;
        case (br)
            0: m_car = c ? tgt : (m_car + 1) % 128;
            1: if (c) begin
                   m_ret = (m_car + 1) % 128;
                   m_car = tgt;
                   m_strobe = 1;
               end else m_car = (m_car + 1) % 128;
            2: m_car = m_ret;
            default: m_car = op * 4;
        endcase
        @(posedge clk);
        @(negedge clk);
        check({tag, " addr"}, car, m_car);
        check({"R10 strobe"}, ret_loaded, m_strobe);
    endtask

    function automatic string br_tag(input int br);
        case (br)
            0: return "R3";
            1: return "R4/R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset addr", car, 64);
        check("R1 reset strobe", ret_loaded, 0);
        rst = 1'b0;
        step(0, 2, 0, 0, 0, 0, 0, 0, "R1 ret after reset");
        step(0, 0, 64, 0, 0, 0, 0, 0, "R3 jump");
        step(1, 0, 5, 0, 0, 0, 0, 0, "R2 dr=0 falls");
        step(1, 0, 5, 0, 0, 1, 0, 0, "R2 dr=1 taken");
        step(2, 0, 30, 0, 0, 1, 0, 1, "R2 ac sign=0");
        step(2, 0, 30, 0, 0, 0, 1, 0, "R2 ac sign=1");
        step(3, 0, 90, 0, 0, 1, 1, 0, "R2 zero=0");
        step(3, 0, 90, 0, 0, 0, 0, 1, "R2 zero=1");
        step(0, 1, 100, 0, 0, 0, 0, 0, "R4 call");
        step(1, 1, 20, 0, 0, 0, 0, 0, "R5 call not taken");
        step(0, 2, 9, 0, 0, 0, 0, 0, "R6 return");
        step(3, 2, 9, 0, 0, 0, 0, 0, "R6 return cond0");
        for (int n = 0; n < 16; n++)
            step(0, 3, 0, 0, n, 0, 0, 0, "R7 map");
        step(0, 0, 127, 0, 0, 0, 0, 0, "R8 to 127");
        step(1, 0, 3, 0, 0, 0, 0, 0, "R8 wrap");
        step(0, 0, 40, 9'h1ff, 0, 0, 0, 0, "R9 ops ones");
        step(1, 1, 40, 9'h1ff, 0, 0, 0, 0, "R9 ops no call");
        for (int i = 0; i < 400; i++) begin
            int br = $urandom_range(0, 3);
            step($urandom_range(0, 3), br, $urandom_range(0, 127),
                 $urandom_range(0, 511), $urandom_range(0, 15),
                 1'($urandom), 1'($urandom), 1'($urandom), br_tag(br));
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule